// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives a synchronous serial bit stream, one bit per strobe, and finds character framing by itself. After reset, and whenever the receiver is disabled or told to, it sits in a hunt state. In that state it only slides a 16-bit window over the arriving bits and compares the window with a pattern built from two programmable sync characters. Once the pattern is seen, framing is fixed, and every following group of eight bits is placed in a receive data register for the host to read.

Each character after the sync pattern goes into a running CRC-16. The CRC error status lags the stream by two characters. The host therefore reads it two character times after the last CRC byte of a block. A character that lands while the previous one is still unread raises a latched overrun flag. An error-clear command drops that flag, and a hunt command sends the receiver back to search for the next block.

Top module: `bsync_rx`

## Requirements
- R1: After reset, and one cycle after `rx_en` is low, `hunt_st` is 1. Reset leaves `rx_avail`, `overrun`, `crc_err`, `first_char` at 0 and `rx_data` at 0x00.
- R2: While hunting, no character is assembled. `rx_avail` does not rise and `rx_data` keeps its value, whatever bits arrive.
- R3: The sync pattern is `{sync_hi, sync_lo}`, compared MSB first with `sync_hi` arriving first. A match needs at least 16 strobed bits since hunting began. `hunt_st` falls in the cycle after the strobe that completes the match.
- R4: The sync bits are never delivered as data. The first character is the next 8 bits. `first_char` is 1 for exactly one cycle, the cycle in which that first character is first visible on `rx_data`, and is 0 for later characters.
- R5: Each group of 8 bits after sync is received MSB first. It appears on `rx_data` with `rx_avail` = 1 in the cycle after its last bit strobe. A `rd_strobe` pulse clears `rx_avail`.
- R6: If a character completes while `rx_avail` is 1 and no `rd_strobe` comes in that cycle, `overrun` is set and latched. The new character replaces `rx_data`.
- R7: A `cmd_err_clr` pulse clears `overrun` on the next cycle. It does not change `rx_avail` or `rx_data`.
- R8: The CRC is CRC-16 with polynomial 0x8005 (x^16+x^15+x^2+1). It is fed MSB first, starts from 0x0000 at each sync match, and takes in every character after sync, CRC bytes included. A block whose two CRC bytes are the CRC of its data leaves residue zero.
- R9: `crc_err` changes only when a character completes. After character k of a block (counting from 0), it equals 1 if the residue after character k-2 is nonzero. After characters 0 and 1 it is 0.
- R10: A `cmd_hunt` pulse puts the receiver back in hunt on the next cycle (`hunt_st` = 1) and discards any partly assembled character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low forces hunt |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new bit this cycle |
| bit_in | input | 1 | Serial data bit |
| sync_hi | input | 8 | First sync character of the pattern |
| sync_lo | input | 8 | Second sync character of the pattern |
| cmd_hunt | input | 1 | Pulse: return to hunt |
| cmd_err_clr | input | 1 | Pulse: clear latched overrun |
| rd_strobe | input | 1 | Pulse: host has read `rx_data` |
| rx_data | output | 8 | Last received character |
| rx_avail | output | 1 | Unread character present |
| first_char | output | 1 | One-cycle flag for the first character after sync |
| overrun | output | 1 | Latched overrun condition |
| hunt_st | output | 1 | 1 while searching for sync |
| crc_err | output | 1 | CRC status, delayed two characters |

## Verification
The bound checker watches the cycle-level rules on every cycle. These are: the hunt bit reacts to disable, to the hunt command and to a sync match; `rx_data` is frozen while hunting; a completed character sets `rx_avail`; overrun sets and clears as described; a read drops `rx_avail`; and `crc_err` moves only on character completion. Only the bench scenarios can show what depends on the stream's content. That covers the MSB-first bit order of the pattern and of the characters, the 16-bit minimum before a match, the CRC residue of good and corrupted blocks, and the exact two-character lag of the error flag across many block lengths and sync patterns.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int CW = 8;          // character width
  localparam int RW = 16;         // CRC width
  localparam logic [RW-1:0] CRC_POLY = 16'h8005;

  typedef logic [CW-1:0] char_t;
  typedef logic [RW-1:0] crc_t;

  // One character into the CRC, MSB first, no reflection, no final xor.
  function automatic crc_t crc_step(input crc_t c, input char_t d, input crc_t poly);
    crc_t r;
    r = c ^ {d, {(RW-CW){1'b0}}};
    for (int i = 0; i < CW; i++) begin
      if (r[RW-1]) r = {r[RW-2:0], 1'b0} ^ poly;
      else         r = {r[RW-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/bsr_hunt.sv
module bsr_hunt
  import bsr_pkg::*;
#(
  parameter int SYNC_W = 2*CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              cmd_hunt,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [SYNC_W-1:0] pattern,
  output logic              hunting,
  output logic              sync_hit
);
  localparam int CNT_W = $clog2(SYNC_W+1);

  logic [SYNC_W-1:0] win;
  logic [SYNC_W-1:0] win_nxt;
  logic [CNT_W-1:0]  seen;
  logic              win_full;

  assign win_nxt  = {win[SYNC_W-2:0], bit_in};
  assign win_full = (seen >= CNT_W'(SYNC_W-1));
  assign sync_hit = rx_en && !cmd_hunt && hunting && bit_vld && win_full &&
                    (win_nxt == pattern);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunting <= 1'b1;
      win     <= '0;
      seen    <= '0;
    end else if (!rx_en || cmd_hunt) begin
      hunting <= 1'b1;
      win     <= '0;
      seen    <= '0;
    end else if (hunting && bit_vld) begin
      win <= win_nxt;
      if (seen != CNT_W'(SYNC_W)) seen <= seen + 1'b1;
      if (sync_hit) hunting <= 1'b0;
    end
  end
endmodule

// File: rtl/bsr_deser.sv
module bsr_deser
  import bsr_pkg::*;
#(
  parameter int CHAR_W = CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              char_done,
  output logic [CHAR_W-1:0] char_val
);
  localparam int BC_W = $clog2(CHAR_W);

  logic [BC_W-1:0]   pos;
  logic [CHAR_W-1:0] sh;

  assign char_done = active && bit_vld && (pos == BC_W'(CHAR_W-1));
  assign char_val  = {sh[CHAR_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      sh  <= '0;
    end else if (!active) begin
      pos <= '0;
    end else if (bit_vld) begin
      sh  <= char_val;
      pos <= char_done ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/bsr_crc_chk.sv
module bsr_crc_chk
  import bsr_pkg::*;
#(
  parameter int   ERR_DLY = 2,
  parameter crc_t POLY    = CRC_POLY
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  char_done,
  input  char_t char_val,
  output logic  crc_bad
);
  crc_t               acc;
  crc_t               acc_nxt;
  logic [ERR_DLY-1:0] zq;

  assign acc_nxt = crc_step(acc, char_val, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      zq      <= '0;
      crc_bad <= 1'b0;
    end else if (clr) begin
      acc <= '0;
      zq  <= '0;
    end else if (char_done) begin
      acc     <= acc_nxt;
      zq[0]   <= |acc_nxt;
      for (int i = 1; i < ERR_DLY; i++) zq[i] <= zq[i-1];
      crc_bad <= zq[ERR_DLY-1];
    end
  end
endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
  import bsr_pkg::*;
#(
  parameter int CHAR_W  = CW,
  parameter int ERR_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [CHAR_W-1:0] sync_hi,
  input  logic [CHAR_W-1:0] sync_lo,
  input  logic              cmd_hunt,
  input  logic              cmd_err_clr,
  input  logic              rd_strobe,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              first_char,
  output logic              overrun,
  output logic              hunt_st,
  output logic              crc_err
);
  localparam int SYNC_W = 2*CHAR_W;

  // named internal events
  logic              hunting;
  logic              sync_hit;
  logic              active;
  logic              char_done;
  logic [CHAR_W-1:0] char_val;
  logic              first_pend;

  assign active  = rx_en && !cmd_hunt && !hunting;
  assign hunt_st = hunting;

  bsr_hunt #(.SYNC_W(SYNC_W)) u_hunt (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cmd_hunt(cmd_hunt),
    .bit_vld(bit_vld), .bit_in(bit_in), .pattern({sync_hi, sync_lo}),
    .hunting(hunting), .sync_hit(sync_hit)
  );

  bsr_deser #(.CHAR_W(CHAR_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .active(active), .bit_vld(bit_vld),
    .bit_in(bit_in), .char_done(char_done), .char_val(char_val)
  );

  bsr_crc_chk #(.ERR_DLY(ERR_DLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(sync_hit), .char_done(char_done),
    .char_val(char_val), .crc_bad(crc_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_avail   <= 1'b0;
      first_char <= 1'b0;
      first_pend <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      first_char <= char_done && first_pend;
      if (sync_hit)                  first_pend <= 1'b1;
      else if (char_done || !active) first_pend <= 1'b0;

      if (char_done)      rx_data <= char_val;
      if (char_done)      rx_avail <= 1'b1;
      else if (rd_strobe) rx_avail <= 1'b0;

      if (char_done && rx_avail && !rd_strobe) overrun <= 1'b1;
      else if (cmd_err_clr)                    overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/bsr_rx_chk.sv
module bsr_rx_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              cmd_hunt,
  input logic              cmd_err_clr,
  input logic              rd_strobe,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_avail,
  input logic              first_char,
  input logic              overrun,
  input logic              hunt_st,
  input logic              crc_err,
  input logic              sync_hit,
  input logic              char_done
);
  p_disable_hunt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> hunt_st);
  p_data_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_st |=> $stable(rx_data));
  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> !hunt_st);
  p_first_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    first_char |-> rx_avail);
  p_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_avail);
  p_read_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> !rx_avail);
  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_avail && !rd_strobe) |=> overrun);
  p_err_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err_clr && !char_done) |=> !overrun);
  p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(crc_err));
  p_hunt_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hunt |=> hunt_st);
endmodule

bind bsync_rx bsr_rx_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cmd_hunt(cmd_hunt),
  .cmd_err_clr(cmd_err_clr), .rd_strobe(rd_strobe), .rx_data(rx_data),
  .rx_avail(rx_avail), .first_char(first_char), .overrun(overrun),
  .hunt_st(hunt_st), .crc_err(crc_err), .sync_hit(sync_hit),
  .char_done(char_done)
);

// File: tb/bsync_rx_tb.sv
module bsync_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic [7:0] sync_hi = 8'h16, sync_lo = 8'h16;
  logic       cmd_hunt = 1'b0, cmd_err_clr = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_avail, first_char, overrun, hunt_st, crc_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bsync_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
    .sync_hi(sync_hi), .sync_lo(sync_lo), .cmd_hunt(cmd_hunt),
    .cmd_err_clr(cmd_err_clr), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_avail(rx_avail), .first_char(first_char), .overrun(overrun),
    .hunt_st(hunt_st), .crc_err(crc_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit-serial reference: one division step per bit
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fbk;
      fbk = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fbk) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_hunt = 1'b1;
      1: cmd_err_clr = 1'b1;
      default: rd_strobe = 1'b1;
    endcase
    @(negedge clk);
    cmd_hunt = 1'b0; cmd_err_clr = 1'b0; rd_strobe = 1'b0;
  endtask

  // send 16-bit pattern, checking R3 lock timing
  task automatic lock_on(input logic [15:0] pat);
    for (int i = 15; i >= 1; i--) send_bit(pat[i]);
    check("R3 still hunting before last sync bit", hunt_st, 1);
    send_bit(pat[0]);
    check("R3 locked after sync", hunt_st, 0);
  endtask

  task automatic run_frame(input logic [15:0] pat, input int len, input int seed, input bit corrupt);
    logic [7:0]  fb [0:15];
    logic        z  [0:15];
    logic [15:0] c;
    logic [7:0]  keep;
    int          n;
    c = 16'h0;
    for (int i = 0; i < len; i++) begin
      fb[i] = 8'((i*37 + len*11 + seed*53 + 5) & 8'hff);
      c = ref_crc(c, fb[i]);
    end
    fb[len]   = c[15:8];
    fb[len+1] = c[7:0] ^ {7'b0, corrupt};
    fb[len+2] = 8'h55;
    fb[len+3] = 8'hAA;
    n = len + 4;
    @(negedge clk); sync_hi = pat[15:8]; sync_lo = pat[7:0];
    keep = rx_data;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check("R2 no char while hunting", rx_avail, 0);
    check("R2 data held while hunting", rx_data, keep);
    lock_on(pat);
    c = 16'h0;
    for (int k = 0; k < n; k++) begin
      send_byte(fb[k]);
      c = ref_crc(c, fb[k]);
      z[k] = (c != 16'h0);
      check("R5 char data", rx_data, fb[k]);
      check("R5 avail set", rx_avail, 1);
      check("R4 first char flag", first_char, (k == 0));
      check("R9 delayed crc status", crc_err, (k >= 2) ? z[k-2] : 1'b0);
      pulse(2);
      check("R5 read clears avail", rx_avail, 0);
    end
    check("R8 block crc result", crc_err, corrupt);
    pulse(0);
    check("R10 hunt after command", hunt_st, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [0:3];
    pats[0] = 16'h1616; pats[1] = 16'h3232; pats[2] = 16'h7E7E; pats[3] = 16'h4B2D;
    repeat (4) @(negedge clk);
    check("R1 reset hunt", hunt_st, 1);
    check("R1 reset avail", rx_avail, 0);
    check("R1 reset overrun", overrun, 0);
    check("R1 reset crc_err", crc_err, 0);
    check("R1 reset first_char", first_char, 0);
    check("R1 reset data", rx_data, 0);
    rst_n = 1'b1;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    check("R1 hunt after enable", hunt_st, 1);

    for (int p = 0; p < 4; p++)
      for (int len = 1; len <= 6; len++)
        for (int cr = 0; cr < 2; cr++)
          run_frame(pats[p], len, p*7 + len, cr[0]);

    // R3 boundary: all-zero pattern needs a full 16 bits after hunt entry
    @(negedge clk); sync_hi = 8'h00; sync_lo = 8'h00;
    pulse(0);
    lock_on(16'h0000);
    send_byte(8'hA5);
    check("R4 first char after zero sync", rx_data, 8'hA5);
    pulse(2);

    // R6 / R7 overrun and clear
    send_byte(8'h11);
    send_byte(8'h22);
    check("R6 overrun set", overrun, 1);
    check("R6 newest char kept", rx_data, 8'h22);
    pulse(1);
    check("R7 overrun cleared", overrun, 0);
    check("R7 avail untouched by clear", rx_avail, 1);
    check("R7 data untouched by clear", rx_data, 8'h22);
    pulse(2);

    // R10 partial character discarded
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    pulse(0);
    check("R10 hunt mid character", hunt_st, 1);
    @(negedge clk); sync_hi = 8'h16; sync_lo = 8'h16;
    lock_on(16'h1616);
    send_byte(8'h3C);
    check("R10 clean framing after re-hunt", rx_data, 8'h3C);
    pulse(2);

    // R1 disable forces hunt
    send_bit(1'b0);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    check("R1 hunt while disabled", hunt_st, 1);
    rx_en = 1'b1;
    lock_on(16'h1616);
    send_byte(8'hC3);
    check("R5 char after re-enable", rx_data, 8'hC3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule